// File: doc/BRIEF.md
# Address-Folded SEC-DED Memory Word Codec

This block protects a 64-bit memory word with eight check bits. On the write side it produces the check byte from the data word and from the address of the access. On the read side it produces the check byte again from the returned data and the current address. It XORs that value with the stored check byte to form a syndrome. From the syndrome it repairs a single flipped data bit, or it raises an uncorrectable flag.

Because the address takes part in the code, data read from the wrong location shows up as an error. The parity-check columns are arranged per aligned 4-bit nibble. As a result, any damage confined to one nibble (two, three or four bits) is reported as uncorrectable and is never miscorrected. A mode input narrows the protected word to its low 32 bits while keeping the same eight check bits. An enable input turns all checking off.

Both paths have one register stage: results appear on the outputs one clock after the inputs are sampled. Sequencing of partial writes, memory timing and module detection are handled outside this block.

Top module: `ecc_fold_codec`

## Requirements
- R1: `wr_check` holds the eight check bits of the `wr_data`/`wr_addr` pair sampled at the previous rising edge. An all-zero data word at address zero encodes to 8'h00.
- R2: A read whose data, address and check byte match a previous encode gives syndrome 8'h00, no flags, and the data unchanged.
- R3: With checking enabled in 64-bit mode, a single flipped data bit at any of the 64 positions is repaired: the output equals the written word, `err_corr`=1, `err_uncorr`=0, and the syndrome is nonzero.
- R4: A single flipped stored check bit j gives syndrome (1<<j) and `err_corr`=1, and the data is passed unchanged.
- R5: Any two flipped data bits give `err_uncorr`=1 and `err_corr`=0, and the raw read data is passed through unmodified.
- R6: A read address that differs from the write address in exactly one bit gives `err_uncorr`=1 and `err_corr`=0, with the data unchanged.
- R7: One differing address bit together with one flipped data bit gives `err_uncorr`=1 and `err_corr`=0.
- R8: Any pattern of two to four flipped bits within one aligned nibble (data bits 4n to 4n+3) gives `err_uncorr`=1 and `err_corr`=0.
- R9: With `wide_mode`=0, data bits 63:32 are treated as zero on both paths. They have no effect on `wr_check` or on the syndrome. While checking is enabled, `rd_data_fix[63:32]` is zero, and single flips in bits 31:0 are repaired.
- R10: With `ecc_en`=0, `rd_data_fix` equals `rd_data` in every mode, both flags are 0, and `err_syn` is 8'h00.
- R11: While reset is held, every output is zero, and `err_corr` and `err_uncorr` are never both 1.
- R12: With checking enabled, `err_syn` equals the recomputed check byte XOR `rd_check`. For example, a correct word stored with check byte XOR 8'h5A reports syndrome 8'h5A and, since that value has even weight, is flagged uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ecc_en | input | 1 | 1 enables checking and correction on the read path |
| wide_mode | input | 1 | 1 selects 64-bit words, 0 selects 32-bit words (bits 31:0) |
| wr_data | input | 64 | Data word to encode |
| wr_addr | input | ADDR_W | Address folded into the encoded check byte |
| wr_check | output | 8 | Registered check byte for the write |
| rd_data | input | 64 | Data word returned from memory |
| rd_check | input | 8 | Check byte returned from memory |
| rd_addr | input | ADDR_W | Address of the read access |
| rd_data_fix | output | 64 | Registered data after correction |
| err_corr | output | 1 | Single-bit data or check-bit error corrected |
| err_uncorr | output | 1 | Error that cannot be corrected |
| err_syn | output | 8 | Registered syndrome, kept for error logging |

## Verification
The bench builds the codec with ADDR_W = 60. This is wider than the 56 address columns the code can assign, so the address bits whose columns wrap around to reused values are driven one at a time alongside those with their own columns. Every data position, every check position and every multi-bit nibble pattern is run against one encoded word in 64-bit mode. The 32-bit mode is then run with random upper-half contents on both paths, so any leak from the ignored half would show on the outputs.

// File: rtl/ecc_fold_pkg.sv
package ecc_fold_pkg;

    localparam int WORD_W    = 64;
    localparam int HALF_W    = WORD_W / 2;
    localparam int CHK_W     = 8;
    localparam int NIB_W     = 4;
    localparam int NIB_N     = WORD_W / NIB_W;
    localparam int PAIR_N    = 6;
    localparam int ADDR_POOL = 56;

    typedef struct packed {
        logic [CHK_W-1:0]  wchk;
        logic [WORD_W-1:0] rdat;
        logic              ce;
        logic              ue;
        logic [CHK_W-1:0]  syn;
    } codec_regs_t;

    // One-hot 4-bit lane selector
    function automatic logic [3:0] unit4(input int p);
        logic [3:0] v;
        v = 4'b0001 << p;
        return v;
    endfunction

    // Six nonzero even-weight 4-bit values other than 4'hF
    function automatic logic [3:0] pair4(input int k);
        logic [3:0] v;
        case (k)
            0:       v = 4'b0011;
            1:       v = 4'b0101;
            2:       v = 4'b0110;
            3:       v = 4'b1001;
            4:       v = 4'b1010;
            default: v = 4'b1100;
        endcase
        return v;
    endfunction

    // Parity-check column of data bit i. Every column has odd weight.
    // Within a nibble the triple and quad XORs never land on a column
    // that the decoder would correct.
    function automatic logic [CHK_W-1:0] data_col(input int i);
        int         n;
        int         p;
        logic [3:0] e;
        n = i / NIB_W;
        p = i % NIB_W;
        e = unit4(p);
        if (n < PAIR_N)            return {pair4(n), e};
        else if (n < 2 * PAIR_N)   return {e, pair4(n - PAIR_N)};
        else if (n == 2 * PAIR_N)  return {4'hF, ~e};
        else if (n == 2 * PAIR_N + 1) return {~e, 4'hF};
        else if (n == 2 * PAIR_N + 2) begin
            if (p < 2) return {4'h0, ~unit4(p)};
            else       return {~unit4(p - 2), 4'h0};
        end else begin
            if (p < 2) return {4'h0, ~unit4(p + 2)};
            else       return {~unit4(p), 4'h0};
        end
    endfunction

    // Address column: odd weight, outside the correctable set, reused
    // cyclically once the pool of such values is exhausted
    function automatic logic [CHK_W-1:0] addr_col(input int k);
        int m;
        m = k % ADDR_POOL;
        if (m < 4 * PAIR_N)      return {pair4(m / 4), ~unit4(m % 4)};
        else if (m < 8 * PAIR_N) return {~unit4((m - 4 * PAIR_N) % 4),
                                         pair4((m - 4 * PAIR_N) / 4)};
        else if (m < 8 * PAIR_N + 4) return {4'hF, unit4(m - 8 * PAIR_N)};
        else                     return {unit4(m - 8 * PAIR_N - 4), 4'hF};
    endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
    import ecc_fold_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [WORD_W-1:0] data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic [CHK_W-1:0]  chk
);

    logic [WORD_W-1:0]             data_m;
    logic [CHK_W-1:0][WORD_W-1:0]  dmask;
    logic [CHK_W-1:0][ADDR_W-1:0]  amask;

    // Narrow words contribute only their low half
    assign data_m = wide ? data : {{HALF_W{1'b0}}, data[HALF_W-1:0]};

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_dcol
        localparam logic [CHK_W-1:0] DC = data_col(gi);
        for (genvar gj = 0; gj < CHK_W; gj++) begin : g_dbit
            assign dmask[gj][gi] = DC[gj];
        end
    end

    for (genvar gk = 0; gk < ADDR_W; gk++) begin : g_acol
        localparam logic [CHK_W-1:0] AC = addr_col(gk);
        for (genvar gj = 0; gj < CHK_W; gj++) begin : g_abit
            assign amask[gj][gk] = AC[gj];
        end
    end

    for (genvar gj = 0; gj < CHK_W; gj++) begin : g_chk
        assign chk[gj] = (^(data_m & dmask[gj])) ^ (^(addr & amask[gj]));
    end

endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
    import ecc_fold_pkg::*;
(
    input  logic [CHK_W-1:0]  syn,
    input  logic              wide,
    output logic [WORD_W-1:0] flip,
    output logic              corr,
    output logic              uncorr
);

    logic [WORD_W-1:0] match;
    logic              data_hit;
    logic              chk_hit;
    logic              nonzero;

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_match
        localparam logic [CHK_W-1:0] DC = data_col(gi);
        if (gi < HALF_W) begin : g_lo
            assign match[gi] = (syn == DC);
        end else begin : g_hi
            // Upper columns are not correctable in narrow mode
            assign match[gi] = wide && (syn == DC);
        end
    end

    always_comb begin
        nonzero  = |syn;
        data_hit = |match;
        chk_hit  = $onehot(syn);
        corr     = nonzero && (data_hit || chk_hit);
        uncorr   = nonzero && !(data_hit || chk_hit);
        flip     = match;
    end

endmodule

// File: rtl/ecc_fold_codec.sv
module ecc_fold_codec
    import ecc_fold_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              wide_mode,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [CHK_W-1:0]  wr_check,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data_fix,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic [CHK_W-1:0]  err_syn
);

    logic [CHK_W-1:0]  wchk_c;
    logic [CHK_W-1:0]  rchk_c;
    logic [CHK_W-1:0]  syn_c;
    logic [WORD_W-1:0] flip_c;
    logic              corr_c;
    logic              uncorr_c;
    logic [WORD_W-1:0] raw_m;
    codec_regs_t       state_d;
    codec_regs_t       state_q;

    ecc_check_gen #(.ADDR_W(ADDR_W)) u_wr_gen (
        .data (wr_data),
        .addr (wr_addr),
        .wide (wide_mode),
        .chk  (wchk_c)
    );

    ecc_check_gen #(.ADDR_W(ADDR_W)) u_rd_gen (
        .data (rd_data),
        .addr (rd_addr),
        .wide (wide_mode),
        .chk  (rchk_c)
    );

    assign syn_c = rchk_c ^ rd_check;

    ecc_syn_decode u_dec (
        .syn    (syn_c),
        .wide   (wide_mode),
        .flip   (flip_c),
        .corr   (corr_c),
        .uncorr (uncorr_c)
    );

    always_comb begin
        state_d      = '0;
        state_d.wchk = wchk_c;
        raw_m        = wide_mode ? rd_data : {{HALF_W{1'b0}}, rd_data[HALF_W-1:0]};
        if (ecc_en) begin
            state_d.syn  = syn_c;
            state_d.ce   = corr_c;
            state_d.ue   = uncorr_c;
            state_d.rdat = corr_c ? (raw_m ^ flip_c) : raw_m;
        end else begin
            state_d.rdat = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wr_check    = state_q.wchk;
    assign rd_data_fix = state_q.rdat;
    assign err_corr    = state_q.ce;
    assign err_uncorr  = state_q.ue;
    assign err_syn     = state_q.syn;

    // Linear code: zero word at address zero encodes to zero
    p_zero_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_data) == '0 && $past(wr_addr) == '0) |-> wr_check == '0);

    p_clean_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_syn == '0) |-> (!err_corr && !err_uncorr));

    p_one_bit_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr && $past(wide_mode)) |->
        $countones(rd_data_fix ^ $past(rd_data)) <= 1);

    p_chk_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr && $onehot(err_syn) && $past(wide_mode)) |->
        rd_data_fix == $past(rd_data));

    p_raw_on_ue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_uncorr && $past(wide_mode)) |-> rd_data_fix == $past(rd_data));

    p_even_syn_ue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_syn != '0 && !(^err_syn)) |-> (err_uncorr && !err_corr));

    p_narrow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ecc_en) && !$past(wide_mode)) |-> rd_data_fix[WORD_W-1:HALF_W] == '0);

    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ecc_en) |-> (!err_corr && !err_uncorr && err_syn == '0 &&
                            rd_data_fix == $past(rd_data)));

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr));

endmodule

// File: tb/ecc_fold_codec_tb.sv
`timescale 1ns/1ps
module ecc_fold_codec_tb;

    localparam int  AW      = 60;
    localparam time CLK_PER = 20ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ecc_en;
    logic          wide_mode;
    logic [63:0]   wr_data;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_check;
    logic [63:0]   rd_data;
    logic [7:0]    rd_check;
    logic [AW-1:0] rd_addr;
    logic [63:0]   rd_data_fix;
    logic          err_corr;
    logic          err_uncorr;
    logic [7:0]    err_syn;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [63:0] d;
        logic        ce;
        logic        ue;
        logic [7:0]  syn;
        bit          syn_any;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    always #(CLK_PER / 2) clk = ~clk;

    ecc_fold_codec #(.ADDR_W(AW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ecc_en      (ecc_en),
        .wide_mode   (wide_mode),
        .wr_data     (wr_data),
        .wr_addr     (wr_addr),
        .wr_check    (wr_check),
        .rd_data     (rd_data),
        .rd_check    (rd_check),
        .rd_addr     (rd_addr),
        .rd_data_fix (rd_data_fix),
        .err_corr    (err_corr),
        .err_uncorr  (err_uncorr),
        .err_syn     (err_syn)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic encode(input logic [63:0] d, input logic [AW-1:0] a, output logic [7:0] c);
        @(negedge clk);
        wr_data = d;
        wr_addr = a;
        @(posedge clk);
        #1;
        c = wr_check;
    endtask

    task automatic set_mode(input logic en, input logic wide);
        @(negedge clk);
        ecc_en    = en;
        wide_mode = wide;
    endtask

    // Driver: apply a read and queue what the outputs must show
    task automatic drive_read(input logic [63:0] d, input logic [7:0] c, input logic [AW-1:0] a,
                              input logic [63:0] ed, input logic ece, input logic eue,
                              input logic [7:0] esyn, input bit any, input string tag);
        exp_t e;
        @(negedge clk);
        rd_data  = d;
        rd_check = c;
        rd_addr  = a;
        e.d = ed; e.ce = ece; e.ue = eue; e.syn = esyn; e.syn_any = any; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: one register stage, so each queued read shows after the next edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            n_checks++;
            if (rd_data_fix !== cur.d || err_corr !== cur.ce || err_uncorr !== cur.ue ||
                (cur.syn_any ? (err_syn == 8'h00) : (err_syn !== cur.syn))) begin
                n_fail++;
                $display("FAIL %s: data %h ce %b ue %b syn %h, expected data %h ce %b ue %b syn %s%h",
                         cur.tag, rd_data_fix, err_corr, err_uncorr, err_syn,
                         cur.d, cur.ce, cur.ue, cur.syn_any ? "nonzero " : "", cur.syn);
            end
        end
    end

    initial begin
        #(CLK_PER * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual run still active, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0]   d0;
        logic [63:0]   lo_w;
        logic [63:0]   junk;
        logic [63:0]   bad;
        logic [AW-1:0] a0;
        logic [AW-1:0] a1;
        logic [7:0]    c0;
        logic [7:0]    c_junk;
        logic [7:0]    c_lo;
        logic [7:0]    ct;

        rst_n     = 1'b0;
        ecc_en    = 1'b1;
        wide_mode = 1'b1;
        wr_data   = 64'hFFFF_0000_A5A5_1234;
        wr_addr   = AW'(64'h0AB_CDEF_1234_5678);
        rd_data   = 64'h1357_9BDF_0246_8ACE;
        rd_check  = 8'hC3;
        rd_addr   = AW'(64'h123_4567_89AB_CDEF);
        repeat (3) @(posedge clk);
        #1;
        // R11: outputs held at zero during reset
        check64("R11 reset wr_check", 64'(wr_check), 64'h0);
        check64("R11 reset rd_data_fix", rd_data_fix, 64'h0);
        check64("R11 reset flags", {62'h0, err_corr, err_uncorr}, 64'h0);
        check64("R11 reset err_syn", 64'(err_syn), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: zero word at address zero
        encode(64'h0, '0, ct);
        check64("R1 zero encode", 64'(ct), 64'h0);

        // R2: clean reads for several words and addresses
        for (int w = 0; w < 4; w++) begin
            logic [63:0]   dw;
            logic [AW-1:0] aw;
            dw = 64'h0123_4567_89AB_CDEF * 64'(w + 3) ^ {32'(w), 32'hF0F0_1E1E};
            aw = AW'(64'h0FED_CBA9_8765_4321) ^ (AW'(w) << 13);
            encode(dw, aw, ct);
            drive_read(dw, ct, aw, dw, 1'b0, 1'b0, 8'h00, 1'b0, "R2 clean");
        end

        d0 = 64'hC0FF_EE12_3456_789A;
        a0 = AW'(64'h0A5_5A5A_F00D_BEEF);
        encode(d0, a0, c0);

        // R3: every single data bit
        for (int i = 0; i < 64; i++)
            drive_read(d0 ^ (64'h1 << i), c0, a0, d0, 1'b1, 1'b0, 8'h00, 1'b1, "R3 single");

        // R4: every single check bit
        for (int j = 0; j < 8; j++)
            drive_read(d0, c0 ^ (8'h01 << j), a0, d0, 1'b1, 1'b0, 8'h01 << j, 1'b0, "R4 check bit");

        // R5: two data bits
        for (int i = 0; i < 64; i++) begin
            int j;
            j   = (i * 7 + 13) % 64;
            bad = d0 ^ (64'h1 << i) ^ (64'h1 << j);
            drive_read(bad, c0, a0, bad, 1'b0, 1'b1, 8'h00, 1'b1, "R5 double");
        end

        // R6: every single address bit, including wrapped columns
        for (int k = 0; k < AW; k++)
            drive_read(d0, c0, a0 ^ (AW'(1) << k), d0, 1'b0, 1'b1, 8'h00, 1'b1, "R6 address");

        // R7: address bit plus data bit
        for (int k = 0; k < 16; k++) begin
            bad = d0 ^ (64'h1 << ((k * 5 + 3) % 64));
            drive_read(bad, c0, a0 ^ (AW'(1) << (k * 3)), bad, 1'b0, 1'b1, 8'h00, 1'b1,
                       "R7 address+data");
        end

        // R8: every multi-bit pattern inside every aligned nibble
        for (int n = 0; n < 16; n++) begin
            for (int m = 1; m < 16; m++) begin
                if ($countones(m) >= 2) begin
                    bad = d0 ^ (64'(m) << (4 * n));
                    drive_read(bad, c0, a0, bad, 1'b0, 1'b1, 8'h00, 1'b1, "R8 nibble");
                end
            end
        end

        // R12: syndrome is recomputed XOR stored
        drive_read(d0, c0 ^ 8'h5A, a0, d0, 1'b0, 1'b1, 8'h5A, 1'b0, "R12 syndrome");

        // R9: narrow mode ignores the upper half
        set_mode(1'b1, 1'b0);
        lo_w = 64'h0000_0000_2468_ACE1;
        junk = 64'h9E37_79B9_2468_ACE1;
        a1   = AW'(64'h0777_0000_1111_2222);
        encode(junk, a1, c_junk);
        encode(lo_w, a1, c_lo);
        check64("R9 upper half ignored by encoder", 64'(c_junk), 64'(c_lo));
        drive_read(junk, c_lo, a1, lo_w, 1'b0, 1'b0, 8'h00, 1'b0, "R9 narrow clean");
        for (int i = 0; i < 32; i++)
            drive_read(junk ^ (64'h1 << i), c_lo, a1, lo_w, 1'b1, 1'b0, 8'h00, 1'b1,
                       "R9 narrow single");

        // R10: checking disabled passes raw data, no flags
        set_mode(1'b0, 1'b1);
        drive_read(d0 ^ 64'h3, c0 ^ 8'hFF, a0 ^ AW'(1), d0 ^ 64'h3, 1'b0, 1'b0, 8'h00, 1'b0,
                   "R10 disabled wide");
        set_mode(1'b0, 1'b0);
        drive_read(junk, 8'h00, a1, junk, 1'b0, 1'b0, 8'h00, 1'b0, "R10 disabled narrow");

        repeat (4) @(posedge clk);
        #2;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule